// File: doc/BRIEF.md
# Coherence miss order logger

This block keeps, for one node, an ordered record of the cache blocks on which that node took coherence misses. The record is a circular log of block addresses held in an on-chip array, with no data stored. Each miss address arrives from the cache side on a valid/ready stream. The low offset bits are stripped, so the log works at cache-block granularity. A miss to the same block as the most recent log entry is folded into that entry. Any other miss writes the next log slot. The write position wraps at the end of the log, and the oldest entries are overwritten without notice.

Every new log entry produces one message for the directory. The message carries this node's number, the slot index that was written and the block address. The directory stores that pointer with the block. When another node later misses on the block, the directory sends a lookup back to this node carrying the stored slot index. The block answers with a fixed-length burst of the block addresses logged after that slot, in the order they were recorded. The requester can then fetch those blocks ahead of use.

Back-pressure rules: a miss is accepted only while the directory message register is empty or is being drained in the same cycle. A held directory message keeps its payload unchanged until it is taken. A lookup is accepted only while no burst is in progress. A replay beat is held, with its data unchanged, until the consumer takes it.

Top module: `mol_logger`

## Requirements
- R1: After reset, dir_valid and rs_valid are 0, miss_ready and lk_ready are 1, and the first log entry written is slot index 0.
- R2: A miss accepted on a block different from the most recent entry writes the current slot. On the next cycle dir_valid is 1, dir_node equals node_id, dir_index equals the slot, and dir_blk equals miss_addr with its low log2(BLK_BYTES) bits removed.
- R3: A miss accepted on the same block as the most recent entry is taken, but it produces no directory message and does not advance the slot index. Addresses that differ only in the low log2(BLK_BYTES) offset bits count as the same block. A difference in any higher bit makes a new block.
- R4: Slot indices of successive directory messages step by one and wrap from DEPTH-1 to 0.
- R5: While dir_valid is 1 and dir_ready is 0, the message payload stays stable and miss_ready is 0. A miss presented during the stall is accepted on the cycle dir_ready returns to 1, and its message follows on the next cycle.
- R6: A lookup accepted with index k is answered starting on the next cycle. The answer is exactly BURST beats carrying the block addresses in slots k+1, k+2, … (modulo DEPTH), in that order. rs_last is 1 on the final beat only, and rs_valid drops after that beat is taken.
- R7: While a replay beat is not taken, rs_blk and rs_last stay stable, and lk_ready stays 0 for the whole burst.
- R8: A lookup that reaches slots overwritten after wrap-around returns the newer addresses stored there. No other validity check is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | NODE_W | Number of this node, copied into each directory message |
| miss_valid | input | 1 | Miss address present |
| miss_ready | output | 1 | Miss address can be taken |
| miss_addr | input | ADDR_W | Byte address of the coherence miss |
| dir_valid | output | 1 | Directory message present |
| dir_ready | input | 1 | Directory takes the message |
| dir_node | output | NODE_W | Recording node number |
| dir_index | output | IDX_W | Log slot written |
| dir_blk | output | BLK_W | Block address logged |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be taken |
| lk_index | input | IDX_W | Log slot located by the directory |
| rs_valid | output | 1 | Replay beat present |
| rs_ready | input | 1 | Replay beat taken |
| rs_blk | output | BLK_W | Replayed block address |
| rs_last | output | 1 | Final beat of the burst |

## Verification
The append path is driven with a sequence of distinct blocks interleaved with same-block repeats at other offsets. This separates real appends from coalesced misses. The sequence runs past twice the log depth, so the index wrap is exercised. A block that differs from the last entry only in its top bit shows that every block bit takes part in the compare. A lookup is issued for every slot index, with a stall placed on varying beats. This exercises the burst wrap past the end of the log and shows that data and rs_last hold under back-pressure. A second lookup of the same region after further appends tells newer data apart from stale data. A stalled directory handshake, with a miss waiting behind it, checks that the held message is stable and that the waiting miss is neither lost nor taken early.

// File: rtl/mol_pkg.sv
package mol_pkg;
  // replay engine state
  typedef enum logic {RP_IDLE, RP_SEND} rp_state_e;

  // default geometry shared by the top and its checker
  localparam int MOL_ADDR_W    = 32;
  localparam int MOL_BLK_BYTES = 64;
  localparam int MOL_DEPTH     = 64;
  localparam int MOL_NODE_W    = 4;
  localparam int MOL_BURST     = 4;
endpackage

// File: rtl/mol_append.sv
// Block-granular coalescing of incoming misses and the circular write pointer.
module mol_append #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int BLK_W  = 26,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              out_free,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BLK_W-1:0]  wr_blk
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] wptr_q;
  logic [BLK_W-1:0] last_blk_q;
  logic             have_last_q;
  logic [BLK_W-1:0] blk;
  logic             accept;
  logic             fresh;

  assign blk        = miss_addr[ADDR_W-1:OFF_W];
  assign miss_ready = out_free;
  assign accept     = miss_valid && out_free;
  assign fresh      = !have_last_q || (blk != last_blk_q);
  assign wr_en      = accept && fresh;
  assign wr_idx     = wptr_q;
  assign wr_blk     = blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q      <= '0;
      last_blk_q  <= '0;
      have_last_q <= 1'b0;
    end else if (wr_en) begin
      last_blk_q  <= blk;
      have_last_q <= 1'b1;
      wptr_q      <= (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/mol_log_ram.sv
// Address-only log storage: one write port, one read port.
module mol_log_ram #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int BLK_W = 26
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [BLK_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [BLK_W-1:0] rdata
);
  logic [BLK_W-1:0] slot_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (widx == IDX_W'(s))) slot_q[s] <= wdata;
    end
  end

  assign rdata = slot_q[ridx];
endmodule

// File: rtl/mol_dir_port.sv
// One-entry output register for directory pointer messages.
module mol_dir_port #(
  parameter int NODE_W = 4,
  parameter int IDX_W  = 6,
  parameter int BLK_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NODE_W-1:0] in_node,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [BLK_W-1:0]  in_blk,
  output logic              free,
  output logic              dir_valid,
  input  logic              dir_ready,
  output logic [NODE_W-1:0] dir_node,
  output logic [IDX_W-1:0]  dir_index,
  output logic [BLK_W-1:0]  dir_blk
);
  assign free = !dir_valid || dir_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_valid <= 1'b0;
      dir_node  <= '0;
      dir_index <= '0;
      dir_blk   <= '0;
    end else if (load) begin
      dir_valid <= 1'b1;
      dir_node  <= in_node;
      dir_index <= in_idx;
      dir_blk   <= in_blk;
    end else if (dir_ready) begin
      dir_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mol_replay.sv
// Replays a fixed-length run of logged blocks following a located slot.
module mol_replay
  import mol_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int BLK_W = 26,
  parameter int BURST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [IDX_W-1:0] lk_index,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [BLK_W-1:0] rd_blk,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic [BLK_W-1:0] rs_blk,
  output logic             rs_last
);
  localparam int               CNT_W    = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BURST - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] v);
    return (v == LAST_IDX) ? '0 : v + 1'b1;
  endfunction

  rp_state_e        state_q;
  logic [IDX_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] blk_q;
  logic             accept;
  logic             take;

  assign lk_ready = (state_q == RP_IDLE);
  assign accept   = lk_valid && lk_ready;
  assign rs_valid = (state_q == RP_SEND);
  assign take     = rs_valid && rs_ready;
  assign rs_last  = rs_valid && (cnt_q == LAST_CNT);
  assign rs_blk   = blk_q;
  assign rd_idx   = accept ? step(lk_index) : step(ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RP_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      blk_q   <= '0;
    end else if (accept) begin
      state_q <= RP_SEND;
      ptr_q   <= step(lk_index);
      cnt_q   <= '0;
      blk_q   <= rd_blk;
    end else if (take) begin
      if (cnt_q == LAST_CNT) begin
        state_q <= RP_IDLE;
      end else begin
        ptr_q <= step(ptr_q);
        cnt_q <= cnt_q + 1'b1;
        blk_q <= rd_blk;
      end
    end
  end
endmodule

// File: rtl/mol_logger.sv
// Coherence miss order logger: top level.
module mol_logger #(
  parameter int ADDR_W    = mol_pkg::MOL_ADDR_W,
  parameter int BLK_BYTES = mol_pkg::MOL_BLK_BYTES,
  parameter int DEPTH     = mol_pkg::MOL_DEPTH,
  parameter int NODE_W    = mol_pkg::MOL_NODE_W,
  parameter int BURST     = mol_pkg::MOL_BURST,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = ADDR_W - OFF_W,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] node_id,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              dir_valid,
  input  logic              dir_ready,
  output logic [NODE_W-1:0] dir_node,
  output logic [IDX_W-1:0]  dir_index,
  output logic [BLK_W-1:0]  dir_blk,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_W-1:0]  lk_index,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [BLK_W-1:0]  rs_blk,
  output logic              rs_last
);
  logic             out_free;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [BLK_W-1:0] wr_blk;
  logic [IDX_W-1:0] rd_idx;
  logic [BLK_W-1:0] rd_blk;

  mol_append #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BLK_W(BLK_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_append (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .out_free(out_free),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_blk(wr_blk)
  );

  mol_log_ram #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .BLK_W(BLK_W)
  ) u_ram (
    .clk(clk), .we(wr_en), .widx(wr_idx), .wdata(wr_blk),
    .ridx(rd_idx), .rdata(rd_blk)
  );

  mol_dir_port #(
    .NODE_W(NODE_W), .IDX_W(IDX_W), .BLK_W(BLK_W)
  ) u_dir (
    .clk(clk), .rst_n(rst_n),
    .load(wr_en), .in_node(node_id), .in_idx(wr_idx), .in_blk(wr_blk),
    .free(out_free),
    .dir_valid(dir_valid), .dir_ready(dir_ready),
    .dir_node(dir_node), .dir_index(dir_index), .dir_blk(dir_blk)
  );

  mol_replay #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .BLK_W(BLK_W), .BURST(BURST)
  ) u_replay (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_index(lk_index),
    .rd_idx(rd_idx), .rd_blk(rd_blk),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_blk(rs_blk), .rs_last(rs_last)
  );
endmodule

// File: rtl/mol_logger_chk.sv
// Protocol and ordering checks, attached to mol_logger by bind.
module mol_logger_chk #(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  parameter int BLK_W  = 26,
  parameter int NODE_W = 4,
  parameter int BURST  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ready,
  input logic              dir_valid,
  input logic              dir_ready,
  input logic [NODE_W-1:0] dir_node,
  input logic [IDX_W-1:0]  dir_index,
  input logic [BLK_W-1:0]  dir_blk,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic [BLK_W-1:0]  rs_blk,
  input logic              rs_last
);
  localparam int               CNT_W    = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BURST - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic             seen_q;
  logic [IDX_W-1:0] prev_q;
  logic [CNT_W-1:0] beats_q;
  logic [IDX_W-1:0] expect_idx;

  assign expect_idx = (prev_q == LAST_IDX) ? '0 : prev_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      prev_q  <= '0;
      beats_q <= '0;
    end else begin
      if (dir_valid && dir_ready) begin
        seen_q <= 1'b1;
        prev_q <= dir_index;
      end
      if (lk_valid && lk_ready) beats_q <= '0;
      else if (rs_valid && rs_ready) beats_q <= beats_q + 1'b1;
    end
  end

  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !seen_q) |-> (dir_index == '0)); // R1
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && seen_q) |-> (dir_index == expect_idx)); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !dir_ready) |=> (dir_valid && $stable(dir_node) && $stable(dir_index) && $stable(dir_blk))); // R5
  AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !dir_ready) |-> !miss_ready); // R5
  AST_BURST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_last == (beats_q == LAST_CNT))); // R6
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_ready && rs_last) |=> !rs_valid); // R6
  AST_RS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_blk) && $stable(rs_last))); // R7
  AST_LK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> !lk_ready); // R7
endmodule

bind mol_logger mol_logger_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .BLK_W(BLK_W), .NODE_W(NODE_W), .BURST(BURST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_ready(miss_ready),
  .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_node(dir_node),
  .dir_index(dir_index), .dir_blk(dir_blk),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_blk(rs_blk), .rs_last(rs_last)
);

// File: tb/tb_mol_logger.sv
module tb_mol_logger;
  localparam int ADDR_W    = 16;
  localparam int BLK_BYTES = 16;
  localparam int DEPTH     = 8;
  localparam int NODE_W    = 3;
  localparam int BURST     = 3;
  localparam int OFF_W     = 4;
  localparam int BLK_W     = ADDR_W - OFF_W;
  localparam int IDX_W     = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NODE_W-1:0] node_id = '0;
  logic              miss_valid = 1'b0;
  logic              miss_ready;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic              dir_valid;
  logic              dir_ready = 1'b1;
  logic [NODE_W-1:0] dir_node;
  logic [IDX_W-1:0]  dir_index;
  logic [BLK_W-1:0]  dir_blk;
  logic              lk_valid = 1'b0;
  logic              lk_ready;
  logic [IDX_W-1:0]  lk_index = '0;
  logic              rs_valid;
  logic              rs_ready = 1'b1;
  logic [BLK_W-1:0]  rs_blk;
  logic              rs_last;

  always #10 clk = ~clk;

  mol_logger #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .DEPTH(DEPTH), .NODE_W(NODE_W), .BURST(BURST)
  ) dut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_node(dir_node),
    .dir_index(dir_index), .dir_blk(dir_blk),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_index(lk_index),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_blk(rs_blk), .rs_last(rs_last)
  );

  int checks = 0;
  int errors = 0;
  logic [BLK_W-1:0] exp_log [DEPTH];
  int               exp_wptr = 0;
  logic [BLK_W-1:0] last_blk = '0;
  bit               have_last = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int blk, input int off);
    return ADDR_W'((blk << OFF_W) | (off & (BLK_BYTES - 1)));
  endfunction

  task automatic note_append(input logic [BLK_W-1:0] b);
    exp_log[exp_wptr] = b;
    exp_wptr = (exp_wptr + 1) % DEPTH;
    last_blk = b;
    have_last = 1'b1;
  endtask

  // Present one miss, then check the directory message one cycle later.
  task automatic miss(input logic [ADDR_W-1:0] a);
    logic [BLK_W-1:0] b;
    bit fresh;
    b = a[ADDR_W-1:OFF_W];
    fresh = !have_last || (b != last_blk);
    @(negedge clk);
    chk("R5 miss_ready before miss", miss_ready, 1);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    if (fresh) begin
      chk("R2 dir_valid after new block", dir_valid, 1);
      chk("R2 dir_node", dir_node, node_id);
      chk("R2 dir_blk", dir_blk, b);
      chk("R4 dir_index step", dir_index, exp_wptr);
      note_append(b);
    end else begin
      chk("R3 no message on coalesced miss", dir_valid, 0);
    end
  endtask

  // Issue a lookup; stall_beat < 0 means no stall.
  task automatic lookup(input int k, input int stall_beat, input string tag);
    @(negedge clk);
    chk("R7 lk_ready idle", lk_ready, 1);
    lk_valid = 1'b1;
    lk_index = IDX_W'(k);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    for (int b = 0; b < BURST; b++) begin
      logic [BLK_W-1:0] e;
      e = exp_log[(k + 1 + b) % DEPTH];
      chk({tag, " rs_valid"}, rs_valid, 1);
      chk({tag, " rs_blk"}, rs_blk, e);
      chk({tag, " rs_last"}, rs_last, (b == BURST - 1));
      chk("R7 lk_ready busy", lk_ready, 0);
      if (b == stall_beat) begin
        rs_ready = 1'b0;
        repeat (2) begin
          @(posedge clk);
          @(negedge clk);
        end
        chk("R7 rs_blk held", rs_blk, e);
        chk("R7 rs_last held", rs_last, (b == BURST - 1));
        chk("R7 rs_valid held", rs_valid, 1);
        rs_ready = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk("R6 rs_valid drops after burst", rs_valid, 0);
    chk("R6 lk_ready after burst", lk_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    node_id = 3'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dir_valid reset", dir_valid, 0);
    chk("R1 rs_valid reset", rs_valid, 0);
    chk("R1 miss_ready reset", miss_ready, 1);
    chk("R1 lk_ready reset", lk_ready, 1);

    // First append lands in slot 0 (R1), the model starts at 0.
    miss(mk(12'h0A5, 3));

    // Fill past two laps with coalesced repeats mixed in (R2, R3, R4).
    for (int i = 0; i < 20; i++) begin
      int blk;
      blk = (i * 37 + 11) % 4096;
      miss(mk(blk, i));
      if (i % 4 == 3) miss(mk(blk, i + 5));
    end

    // Only the top block bit differs: a new block (R3).
    miss(mk(int'(last_blk) ^ 12'h800, 0));
    // Same block, other offset: coalesced (R3).
    miss(mk(int'(last_blk), 15));

    // Every lookup index, burst wraps past the end (R6, R7).
    for (int k = 0; k < DEPTH; k++) begin
      lookup(k, (k % 2 == 1) ? (k % BURST) : -1, "R6 sweep");
    end

    // Overwrite part of the log and look up the same region again (R8).
    lookup(exp_wptr, -1, "R8 before overwrite");
    for (int i = 0; i < DEPTH / 2; i++) miss(mk(12'h300 + i, i));
    lookup((exp_wptr + DEPTH - 6) % DEPTH, 1, "R8 after overwrite");

    // Node field follows the input (R2).
    node_id = 3'd2;
    miss(mk(12'h777, 1));

    // Directory back-pressure with a miss waiting (R5).
    @(negedge clk);
    dir_ready = 1'b0;
    miss(mk(12'h123, 2));
    begin
      logic [IDX_W-1:0] held_idx;
      logic [BLK_W-1:0] pend_blk;
      held_idx = dir_index;
      pend_blk = 12'h456;
      miss_valid = 1'b1;
      miss_addr  = mk(12'h456, 9);
      repeat (3) begin
        @(posedge clk);
        @(negedge clk);
        chk("R5 dir_valid held", dir_valid, 1);
        chk("R5 dir_index held", dir_index, held_idx);
        chk("R5 dir_blk held", dir_blk, 12'h123);
        chk("R5 miss_ready low", miss_ready, 0);
      end
      dir_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      miss_valid = 1'b0;
      chk("R5 waiting miss issued", dir_valid, 1);
      chk("R5 waiting miss index", dir_index, exp_wptr);
      chk("R5 waiting miss blk", dir_blk, pend_blk);
      note_append(pend_blk);
      @(posedge clk);
      @(negedge clk);
      chk("R5 message drained", dir_valid, 0);
    end
    lookup((exp_wptr + DEPTH - 3) % DEPTH, 0, "R6 after stall");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule